// File: doc/BRIEF.md
# Watchdog and System Reset Controller

This block generates the chip's system reset from three sources. The first is a power-on hold-off. The second is a low-supply flag. The third is a watchdog counter that software has to refresh inside a chosen window. The watchdog counts a slow tick enable rather than the clock, so one tick can stand for a fixed slice of real time.

A two-bit select code picks a timeout of 1, 2, 4 or 16 times a base number of ticks. A configuration bit decides whether counting goes on while the core sits in its low-power stop state. A newly written select code waits in a holding register and only becomes active at the next refresh. Because of this, a mode change can never shorten the window that is already running.

On expiry the watchdog asserts its reset for a fixed number of clock cycles and then starts again from zero. The three sources are ORed and registered into one glitch-free reset output. All of the control pins are plain level or strobe signals.

Top module: `wdt_reset_ctrl`

## Requirements
- R1: While `pwr_good` is low, `sys_rst` is 1 (asynchronous clear). After `pwr_good` rises, `sys_rst` stays 1 until POR_TICKS tick pulses have been seen. It falls in the cycle after the clock edge that accepts the last of those pulses, and it does not rise again from this source while power stays good.
- R2: `low_supply` high sets `sys_rst` to 1 at the next clock edge and holds it there. It also clears the watchdog count to zero. After it drops, `sys_rst` falls at the next edge, provided no other source is active.
- R3: The terminal count is BASE_TICKS times 1, 2, 4 or 16, for an active select code of 0, 1, 2 or 3 respectively. The edge that accepts the tick bringing the count to the terminal value starts the watchdog reset. `sys_rst` is 1 from the following edge onward.
- R4: A `kick` strobe clears the count to zero. When a kick and the terminal tick arrive in the same cycle, the kick wins and no reset is produced.
- R5: `cfg_wr` stores `cfg_sel` into a pending register. The active select code copies the pending value only on a `kick` edge. Both registers are 0 after reset.
- R6: With `stop_mode` high and the run-in-stop bit at 0, ticks are not counted. With the bit at 1, ticks are counted during stop. The run-in-stop bit acts from the edge that writes it.
- R7: A watchdog expiry holds `sys_rst` high for exactly RST_CYCLES clock cycles. Kicks during that time are ignored. Afterwards the count restarts from zero.
- R8: While the power-on hold-off is active, ticks do not advance the watchdog count.
- R9: `sys_rst` is a register output. It equals the OR of the three sources as sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_good | input | 1 | Supply up; low clears every register asynchronously |
| low_supply | input | 1 | Low-supply detect, active high |
| tick | input | 1 | Slow time-base enable, one clock wide per tick |
| cfg_wr | input | 1 | Write strobe for the configuration fields |
| cfg_sel | input | 2 | Timeout select code to be held pending |
| cfg_run_stop | input | 1 | 1 = keep counting in stop mode |
| kick | input | 1 | Software refresh strobe |
| stop_mode | input | 1 | Core is in stop mode |
| sys_rst | output | 1 | Combined system reset, active high |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a refresh and the terminal tick. The bench brings the count to one below the terminal value and then drives `kick` and `tick` together. It judges the outcome on two counts: `sys_rst` must stay low, and expiry must then need a full new window. The second pair is a refresh and a running watchdog reset. The bench drives `kick` through the whole pulse and checks two things: the pulse still lasts exactly RST_CYCLES cycles, and a full window is again needed afterwards.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WSEL_X1  = 2'd0,
    WSEL_X2  = 2'd1,
    WSEL_X4  = 2'd2,
    WSEL_X16 = 2'd3
  } wdt_sel_e;

  function automatic int unsigned wdt_mult(input wdt_sel_e s);
    case (s)
      WSEL_X1:  return 1;
      WSEL_X2:  return 2;
      WSEL_X4:  return 4;
      default:  return 16;
    endcase
  endfunction
endpackage

// File: rtl/wdt_por_hold.sv
module wdt_por_hold #(
  parameter int unsigned POR_TICKS = 10
) (
  input  logic clk,
  input  logic pwr_good,
  input  logic tick,
  output logic por_hold
);
  localparam int unsigned PCW = $clog2(POR_TICKS + 1);
  localparam logic [PCW-1:0] PDONE = PCW'(POR_TICKS);

  logic [PCW-1:0] por_cnt;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good)                     por_cnt <= '0;
    else if (tick && por_cnt != PDONE) por_cnt <= por_cnt + 1'b1;
  end

  assign por_hold = (por_cnt != PDONE);

  assert_hold_released_stays_R1: assert property (@(posedge clk) disable iff (!pwr_good)
    !por_hold |=> !por_hold);
  assert_hold_needs_tick_R1: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(por_hold) |-> $past(tick));
endmodule

// File: rtl/wdt_cfg.sv
module wdt_cfg
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       pwr_good,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_sel,
  input  logic       cfg_run_stop,
  input  logic       kick,
  output wdt_sel_e   sel_act,
  output logic       run_stop
);
  wdt_sel_e sel_pend;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      sel_pend <= WSEL_X1;
      run_stop <= 1'b0;
    end else if (cfg_wr) begin
      sel_pend <= wdt_sel_e'(cfg_sel);
      run_stop <= cfg_run_stop;
    end
  end

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good)  sel_act <= WSEL_X1;
    else if (kick)  sel_act <= sel_pend;
  end

  assert_sel_only_on_kick_R5: assert property (@(posedge clk) disable iff (!pwr_good)
    !kick |=> $stable(sel_act));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 5,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic     clk,
  input  logic     pwr_good,
  input  logic     enable,
  input  logic     tick,
  input  logic     halt,
  input  logic     kick,
  input  wdt_sel_e sel_act,
  output logic     bark
);
  localparam int unsigned TERM_MAX = 16 * BASE_TICKS;
  localparam int unsigned CW  = $clog2(TERM_MAX + 1);
  localparam int unsigned PW  = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic [PW-1:0] pulse;
  logic [CW-1:0] term;
  logic          busy;

  assign term = CW'(BASE_TICKS * wdt_mult(sel_act));
  assign busy = (pulse != '0);
  assign bark = busy;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      cnt   <= '0;
      pulse <= '0;
    end else if (!enable) begin
      cnt   <= '0;
      pulse <= '0;
    end else if (busy) begin
      cnt   <= '0;
      pulse <= pulse - 1'b1;
    end else if (kick) begin
      cnt   <= '0;
    end else if (tick && !halt) begin
      if (cnt == term - 1'b1) begin
        cnt   <= '0;
        pulse <= PW'(RST_CYCLES);
      end else begin
        cnt   <= cnt + 1'b1;
      end
    end
  end

  assert_kick_clears_R4: assert property (@(posedge clk) disable iff (!pwr_good)
    enable && !busy && kick |=> cnt == '0 && !bark);
  assert_halt_freezes_R6: assert property (@(posedge clk) disable iff (!pwr_good)
    enable && !busy && !kick && halt |=> $stable(cnt));
  assert_bark_from_tick_R3: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(bark) |-> $past(tick && !halt && !kick && enable));
  assert_idle_while_disabled_R8: assert property (@(posedge clk) disable iff (!pwr_good)
    !enable |=> cnt == '0 && !bark);
  assert_count_in_range_R3: assert property (@(posedge clk) disable iff (!pwr_good)
    cnt < term || $past(kick) || $changed(sel_act));
endmodule

// File: rtl/wdt_reset_ctrl.sv
module wdt_reset_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned BASE_TICKS = 5,
  parameter int unsigned POR_TICKS  = 10,
  parameter int unsigned RST_CYCLES = 16
) (
  input  logic       clk,
  input  logic       pwr_good,
  input  logic       low_supply,
  input  logic       tick,
  input  logic       cfg_wr,
  input  logic [1:0] cfg_sel,
  input  logic       cfg_run_stop,
  input  logic       kick,
  input  logic       stop_mode,
  output logic       sys_rst
);
  logic     por_hold;
  logic     run_stop;
  logic     bark;
  logic     wd_enable;
  logic     halt;
  wdt_sel_e sel_act;

  wdt_por_hold #(.POR_TICKS(POR_TICKS)) u_por (
    .clk(clk), .pwr_good(pwr_good), .tick(tick), .por_hold(por_hold)
  );

  wdt_cfg u_cfg (
    .clk(clk), .pwr_good(pwr_good), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_run_stop(cfg_run_stop), .kick(kick), .sel_act(sel_act), .run_stop(run_stop)
  );

  assign wd_enable = !por_hold && !low_supply;
  assign halt      = stop_mode && !run_stop;

  wdt_counter #(.BASE_TICKS(BASE_TICKS), .RST_CYCLES(RST_CYCLES)) u_cnt (
    .clk(clk), .pwr_good(pwr_good), .enable(wd_enable), .tick(tick), .halt(halt),
    .kick(kick), .sel_act(sel_act), .bark(bark)
  );

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) sys_rst <= 1'b1;
    else           sys_rst <= por_hold | low_supply | bark;
  end

  assert_low_supply_resets_R2: assert property (@(posedge clk) disable iff (!pwr_good)
    low_supply |=> sys_rst);
  assert_hold_resets_R1: assert property (@(posedge clk) disable iff (!pwr_good)
    por_hold |=> sys_rst);
  assert_release_clean_R9: assert property (@(posedge clk) disable iff (!pwr_good)
    $fell(sys_rst) |-> !$past(low_supply) && !$past(bark) && !$past(por_hold));
endmodule

// File: tb/test_wdt_reset_ctrl.sv
module test_wdt_reset_ctrl;
  localparam int unsigned BASE = 3;
  localparam int unsigned POR  = 4;
  localparam int unsigned RSTC = 4;

  logic clk = 1'b0;
  logic pwr_good = 1'b0, low_supply = 1'b0, tick = 1'b0, cfg_wr = 1'b0;
  logic [1:0] cfg_sel = 2'd0;
  logic cfg_run_stop = 1'b0, kick = 1'b0, stop_mode = 1'b0;
  logic sys_rst;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_reset_ctrl #(.BASE_TICKS(BASE), .POR_TICKS(POR), .RST_CYCLES(RSTC)) i_wdt_reset_ctrl (
    .clk(clk), .pwr_good(pwr_good), .low_supply(low_supply), .tick(tick),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_run_stop(cfg_run_stop),
    .kick(kick), .stop_mode(stop_mode), .sys_rst(sys_rst)
  );

  typedef struct packed {
    logic [1:0] sel;
    logic [7:0] nticks;
    logic       exp_rst;
  } vec_t;

  // R3: terminal = BASE * {1,2,4,16}; one tick short stays quiet, exact count expires
  localparam vec_t VECS [8] = '{
    '{2'd0, 8'd2,  1'b0}, '{2'd0, 8'd3,  1'b1},
    '{2'd1, 8'd5,  1'b0}, '{2'd1, 8'd6,  1'b1},
    '{2'd2, 8'd11, 1'b0}, '{2'd2, 8'd12, 1'b1},
    '{2'd3, 8'd47, 1'b0}, '{2'd3, 8'd48, 1'b1}
  };

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic tk, input logic kk);
    @(negedge clk);
    tick = tk; kick = kk; cfg_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) drive(1'b1, 1'b0);
  endtask

  // one idle edge registers the result; sample at the following negedge
  task automatic settle_sample(input string req, input logic exp);
    drive(1'b0, 1'b0);
    @(negedge clk);
    tick = 1'b0; kick = 1'b0;
    check(req, sys_rst, exp);
  endtask

  task automatic write_cfg(input logic [1:0] s, input logic rs);
    @(negedge clk);
    tick = 1'b0; kick = 1'b0;
    cfg_wr = 1'b1; cfg_sel = s; cfg_run_stop = rs;
  endtask

  task automatic wait_clear(input string req);
    for (int i = 0; i < int'(RSTC) + 3; i++) drive(1'b0, 1'b0);
    check(req, sys_rst, 1'b0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int hi;
    // R1: reset state while power is not good
    repeat (3) @(negedge clk);
    check("R1 power down", sys_rst, 1'b1);
    pwr_good = 1'b1;
    ticks(POR - 1);
    settle_sample("R1 hold-off not yet done", 1'b1);
    ticks(1);
    settle_sample("R1 hold-off released", 1'b0);
    // R8: the POR ticks must not have advanced the watchdog (sel 0 term 3)
    ticks(2);
    settle_sample("R8 count idle during hold-off", 1'b0);

    // table walk, R3 and R7 (restart after pulse)
    foreach (VECS[k]) begin
      write_cfg(VECS[k].sel, 1'b0);
      drive(1'b0, 1'b1);
      ticks(int'(VECS[k].nticks));
      settle_sample($sformatf("R3 vector %0d", k), VECS[k].exp_rst);
      if (VECS[k].exp_rst) wait_clear($sformatf("R7 vector %0d pulse ended", k));
    end

    // R2: low supply forces reset and clears count
    write_cfg(2'd0, 1'b0);
    drive(1'b0, 1'b1);
    ticks(2);
    @(negedge clk); tick = 1'b0; low_supply = 1'b1;
    @(negedge clk);
    check("R2 low supply asserts", sys_rst, 1'b1);
    low_supply = 1'b0;
    @(negedge clk);
    check("R2 low supply release", sys_rst, 1'b0);
    ticks(2);
    settle_sample("R2 count cleared", 1'b0);
    ticks(1);
    settle_sample("R2 full window after low supply", 1'b1);
    wait_clear("R7 after R2 expiry");

    // R6: stop-mode freeze vs. run-through
    write_cfg(2'd0, 1'b0);
    drive(1'b0, 1'b1);
    stop_mode = 1'b1;
    ticks(6);
    settle_sample("R6 frozen in stop", 1'b0);
    write_cfg(2'd0, 1'b1);
    ticks(3);
    settle_sample("R6 runs in stop", 1'b1);
    wait_clear("R7 after R6 expiry");
    stop_mode = 1'b0;

    // R5: pending select not used until a kick
    write_cfg(2'd0, 1'b0);
    drive(1'b0, 1'b1);
    write_cfg(2'd3, 1'b0);
    ticks(3);
    settle_sample("R5 old select still active", 1'b1);
    wait_clear("R7 after R5 expiry");

    // R4: kick coincides with terminal tick
    write_cfg(2'd0, 1'b0);
    drive(1'b0, 1'b1);
    ticks(2);
    drive(1'b1, 1'b1);
    settle_sample("R4 kick wins over terminal tick", 1'b0);
    ticks(2);
    settle_sample("R4 count restarted", 1'b0);
    ticks(1);
    settle_sample("R4 new window expires", 1'b1);
    wait_clear("R7 after R4 expiry");

    // R7: pulse width with kicks held through it
    drive(1'b0, 1'b1);
    ticks(3);
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      hi += int'(sys_rst);
      tick = 1'b0; kick = 1'b1;
    end
    kick = 1'b0;
    checks++;
    if (hi != int'(RSTC)) begin
      errors++;
      $display("FAIL R7 pulse width: actual=%0d expected=%0d", hi, RSTC);
    end
    ticks(2);
    settle_sample("R7 restart from zero", 1'b0);
    // R9: registered combine, low supply visible one edge later
    @(negedge clk); low_supply = 1'b1;
    check("R9 not yet registered", sys_rst, 1'b0);
    @(negedge clk); low_supply = 1'b0;
    check("R9 registered", sys_rst, 1'b1);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule